// File: doc/BRIEF.md
# Burst Column Address and Latency Sequencer

This block turns a two-step column access into a timed four-beat burst. A read or write command comes first. A second command, the address strobe, follows and carries the column start address. The block then waits a programmed number of cycles and asserts a per-direction data strobe for four consecutive cycles. On each of those cycles it presents the beat index and the column address of that beat. It is meant to sit inside a DRAM device model or a memory controller, next to the array access and data-path logic.

A small mode register holds a 3-bit latency code and a burst-order bit. The latency code is the number of cycles from the address strobe to the first read beat. Writes are sampled one cycle earlier than reads. Only codes 4 to 7 are usable. A lower code raises an error flag and blocks new accesses until a usable code is written. The mode is captured when the read or write command is accepted, so a later mode write cannot change a burst that has already started.

Top module: `burst_col_seq`

## Requirements
- R1: After reset the block is idle: both strobes, `busy_o` and `err_o` are low, and the mode is sequential order with latency 4.
- R2: A mode write places the latency code in `mode_i[6:4]` and the burst order in `mode_i[3]` (0 sequential, 1 interleave). Codes 4, 5, 6 and 7 give latencies of 4, 5, 6 and 7 cycles.
- R3: For a read, count the clock edge that samples the address strobe as edge 0. `rd_en_o` is first high after edge L, where L is the captured latency.
- R4: For a write, `wr_en_o` is first high after edge L-1, counted the same way.
- R5: A data strobe stays high for exactly four consecutive cycles. `beat_o` reads 0, 1, 2 and 3 on those cycles, and only one of `rd_en_o` and `wr_en_o` is high at any time.
- R6: In sequential order, bits 1:0 of `col_o` equal (start + beat) mod 4. Bits above 1 equal the start address and never take a carry.
- R7: In interleave order, bits 1:0 of `col_o` equal the start bits 1:0 XOR the beat index. The upper bits equal the start address.
- R8: While the stored latency code is 0 to 3, `err_o` is high and a read or write command is ignored, so no burst and no busy follow.
- R9: `busy_o` goes high after an accepted command and stays high up to and including the last beat. Commands and address strobes that arrive while busy are ignored.
- R10: Latency and burst order are captured when the read or write command is accepted. Mode writes after that point do not change the burst in progress.
- R11: An address strobe with no accepted command before it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_we_i | input | 1 | Mode register write enable |
| mode_i | input | 7 | Mode word: [6:4] latency code, [3] burst order |
| rd_cmd_i | input | 1 | Read command, first part of an access |
| wr_cmd_i | input | 1 | Write command, first part of an access |
| addr_stb_i | input | 1 | Address strobe, second part of an access |
| col_i | input | 9 | Column start address, sampled with the address strobe |
| busy_o | output | 1 | Access in progress |
| err_o | output | 1 | Stored latency code is reserved |
| rd_en_o | output | 1 | Read data beat is driven this cycle |
| wr_en_o | output | 1 | Write data beat is sampled this cycle |
| beat_o | output | 2 | Beat index within the burst |
| col_o | output | 9 | Column address of the current beat |

## Verification
The assertions assume that `rd_cmd_i` and `wr_cmd_i` are never high in the same cycle. They also assume that every input changes only between clock edges, so that the command, strobe and mode write seen at an edge are the ones the bench meant. The stimulus keeps to both: it changes inputs only on the falling edge and asserts one command at a time. It covers every legal latency code, both directions, both burst orders and all four start offsets, each on its own idle access. Commands, strobes and mode writes that should be ignored are placed on purpose inside the wait window of a long burst, and in front of a reserved code.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_WAIT  = 2'd2,
    ST_BURST = 2'd3
  } bcs_state_e;

  localparam int unsigned BEAT_W = 2;
  localparam int unsigned BURST_LEN = 1 << BEAT_W;
endpackage

// File: rtl/bcs_mode_reg.sv
module bcs_mode_reg #(
  parameter int unsigned MODE_W  = 7,
  parameter int unsigned LAT_W   = 3,
  parameter int unsigned LAT_LSB = 4,
  parameter int unsigned BT_BIT  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [MODE_W-1:0] mode_i,
  output logic [LAT_W-1:0]  lat_o,
  output logic              bt_o,
  output logic              err_o
);
  localparam logic [LAT_W-1:0] LAT_RST = LAT_W'(4);

  logic [LAT_W-1:0] lat_q;
  logic             bt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q <= LAT_RST;
      bt_q  <= 1'b0;
    end else if (we_i) begin
      lat_q <= mode_i[LAT_LSB +: LAT_W];
      bt_q  <= mode_i[BT_BIT];
    end
  end

  assign lat_o = lat_q;
  assign bt_o  = bt_q;
  // codes below 4 are reserved
  assign err_o = (lat_q < LAT_W'(4));

  a_r2_mode_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (lat_o == $past(mode_i[LAT_LSB +: LAT_W])) && (bt_o == $past(mode_i[BT_BIT])));
endmodule

// File: rtl/bcs_timer.sv
module bcs_timer
  import bcs_pkg::*;
#(
  parameter int unsigned LAT_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic              stb_i,
  input  logic [LAT_W-1:0]  lat_i,
  input  logic              bt_i,
  input  logic              err_i,
  output logic              take_o,
  output logic              busy_o,
  output logic              rd_en_o,
  output logic              wr_en_o,
  output logic              bt_o,
  output logic [BEAT_W-1:0] beat_o
);
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BURST_LEN - 1);

  bcs_state_e       st_q;
  logic [LAT_W-1:0] lat_q, cnt_q;
  logic             wr_q, bt_q;
  logic [BEAT_W-1:0] beat_q;

  assign take_o = (st_q == ST_ARMED) && stb_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      lat_q  <= '0;
      cnt_q  <= '0;
      wr_q   <= 1'b0;
      bt_q   <= 1'b0;
      beat_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if ((rd_i || wr_i) && !err_i) begin
          st_q  <= ST_ARMED;
          lat_q <= lat_i;
          bt_q  <= bt_i;
          wr_q  <= !rd_i;
        end
        ST_ARMED: if (stb_i) begin
          st_q  <= ST_WAIT;
          // writes land one cycle ahead of reads
          cnt_q <= wr_q ? lat_q - 1'b1 : lat_q;
        end
        ST_WAIT: begin
          if (cnt_q == LAT_W'(1)) begin
            st_q   <= ST_BURST;
            beat_q <= '0;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_BURST: begin
          beat_q <= beat_q + 1'b1;
          if (beat_q == LAST_BEAT) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o  = (st_q != ST_IDLE);
  assign rd_en_o = (st_q == ST_BURST) && !wr_q;
  assign wr_en_o = (st_q == ST_BURST) && wr_q;
  assign bt_o    = bt_q;
  assign beat_o  = beat_q;

  a_r5_beat_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rd_en_o || wr_en_o) && beat_o != LAST_BEAT)
      |=> (rd_en_o || wr_en_o) && (beat_o == $past(beat_o) + 1'b1));
  a_r5_burst_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rd_en_o || wr_en_o) && beat_o == LAST_BEAT) |=> !(rd_en_o || wr_en_o));
  a_r5_one_dir: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rd_en_o, wr_en_o}));
  a_r8_reserved_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && (rd_i || wr_i) && err_i) |=> !busy_o);
  a_r9_busy_covers: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_o || wr_en_o) |-> busy_o);
  a_r10_dir_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_o && $past(busy_o)) |-> !$past(wr_en_o));
  a_r11_stb_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !rd_i && !wr_i) |=> !busy_o);
endmodule

// File: rtl/bcs_addr_gen.sv
module bcs_addr_gen
  import bcs_pkg::*;
#(
  parameter int unsigned COL_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic              en_i,
  input  logic              bt_i,
  input  logic [BEAT_W-1:0] beat_i,
  output logic [COL_W-1:0]  col_o
);
  logic [COL_W-1:0]  col_q;
  logic [BEAT_W-1:0] low;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     col_q <= '0;
    else if (take_i) col_q <= col_i;
  end

  // order wraps inside the low field, never carries upward
  assign low   = bt_i ? (col_q[BEAT_W-1:0] ^ beat_i) : (col_q[BEAT_W-1:0] + beat_i);
  assign col_o = {col_q[COL_W-1:BEAT_W], low};

  a_r6_upper_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && $past(en_i)) |-> $stable(col_o[COL_W-1:BEAT_W]));
  a_r7_first_beat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && beat_i == '0) |-> (col_o == col_q));
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import bcs_pkg::*;
#(
  parameter int unsigned COL_W   = 9,
  parameter int unsigned MODE_W  = 7,
  parameter int unsigned LAT_W   = 3,
  parameter int unsigned LAT_LSB = 4,
  parameter int unsigned BT_BIT  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_we_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              rd_cmd_i,
  input  logic              wr_cmd_i,
  input  logic              addr_stb_i,
  input  logic [COL_W-1:0]  col_i,
  output logic              busy_o,
  output logic              err_o,
  output logic              rd_en_o,
  output logic              wr_en_o,
  output logic [BEAT_W-1:0] beat_o,
  output logic [COL_W-1:0]  col_o
);
  logic [LAT_W-1:0] lat;
  logic             bt_mode, bt_cap, take;

  bcs_mode_reg #(.MODE_W(MODE_W), .LAT_W(LAT_W), .LAT_LSB(LAT_LSB), .BT_BIT(BT_BIT)) u_mode (
    .clk_i, .rst_ni, .we_i(mode_we_i), .mode_i,
    .lat_o(lat), .bt_o(bt_mode), .err_o
  );

  bcs_timer #(.LAT_W(LAT_W)) u_timer (
    .clk_i, .rst_ni, .rd_i(rd_cmd_i), .wr_i(wr_cmd_i), .stb_i(addr_stb_i),
    .lat_i(lat), .bt_i(bt_mode), .err_i(err_o), .take_o(take), .busy_o,
    .rd_en_o, .wr_en_o, .bt_o(bt_cap), .beat_o
  );

  bcs_addr_gen #(.COL_W(COL_W)) u_addr (
    .clk_i, .rst_ni, .take_i(take), .col_i, .en_i(rd_en_o || wr_en_o),
    .bt_i(bt_cap), .beat_i(beat_o), .col_o
  );
endmodule

// File: tb/burst_col_seq_tb_top.sv
module burst_col_seq_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_we = 1'b0;
  logic [6:0] mode = '0;
  logic       rd_cmd = 1'b0, wr_cmd = 1'b0, stb = 1'b0;
  logic [8:0] col = '0;
  logic       busy, err, rd_en, wr_en;
  logic [1:0] beat;
  logic [8:0] col_out;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  burst_col_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .mode_we_i(mode_we), .mode_i(mode),
    .rd_cmd_i(rd_cmd), .wr_cmd_i(wr_cmd), .addr_stb_i(stb), .col_i(col),
    .busy_o(busy), .err_o(err), .rd_en_o(rd_en), .wr_en_o(wr_en),
    .beat_o(beat), .col_o(col_out)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_mode(input int code, input bit bt);
    @(negedge clk);
    mode = {code[2:0], bt, 3'b000};
    mode_we = 1'b1;
    @(negedge clk);
    mode_we = 1'b0;
  endtask

  // one access; inj adds ignored traffic and a mode write during the wait (R9, R10)
  task automatic access(input bit is_wr, input bit bt, input int lat, input int c, input bit inj);
    int d;
    int exp_col;
    d = is_wr ? lat - 1 : lat;
    @(negedge clk);
    rd_cmd = !is_wr; wr_cmd = is_wr;
    @(negedge clk);
    rd_cmd = 1'b0; wr_cmd = 1'b0;
    stb = 1'b1; col = c[8:0];
    if (inj) begin
      mode = {3'd4, ~bt, 3'b000};
      mode_we = 1'b1;
    end
    @(negedge clk);
    stb = 1'b0; mode_we = 1'b0;
    for (int k = 1; k <= d + 4; k++) begin
      if (inj && k == 1) rd_cmd = 1'b1;
      if (inj && k == 2) begin rd_cmd = 1'b0; stb = 1'b1; col = ~c[8:0]; end
      if (inj && k == 3) stb = 1'b0;
      @(negedge clk);
      if (k < d) begin
        chk(busy && !rd_en && !wr_en, is_wr ? "R4 wait" : "R3 wait", {busy, rd_en, wr_en}, 4);
      end else if (k < d + 4) begin
        exp_col = (c & ~3) | (bt ? ((c ^ (k - d)) & 3) : ((c + k - d) & 3));
        chk(rd_en == !is_wr && wr_en == is_wr, is_wr ? "R4 strobe" : "R3 strobe",
            {rd_en, wr_en}, is_wr ? 1 : 2);
        chk(int'(beat) == k - d, "R5 beat", beat, k - d);
        chk(int'(col_out) == exp_col, bt ? "R7 col" : "R6 col", col_out, exp_col);
        chk(busy, inj ? "R9 busy" : "R5 busy", busy, 1);
      end else begin
        chk(!rd_en && !wr_en && !busy, "R5 end", {busy, rd_en, wr_en}, 0);
      end
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !err && !rd_en && !wr_en, "R1 reset", {busy, err, rd_en, wr_en}, 0);
    access(1'b0, 1'b0, 4, 9'h0A7, 1'b0); // R1 default: sequential, latency 4

    for (int code = 4; code < 8; code++)
      for (int bt = 0; bt < 2; bt++) begin
        set_mode(code, bt[0]);
        chk(!err, "R2 legal code", err, 0);
        for (int w = 0; w < 2; w++)
          for (int lo = 0; lo < 4; lo++)
            access(w[0], bt[0], code, 9'h1B4 | lo, 1'b0);
      end

    // R8 reserved codes
    for (int code = 0; code < 4; code++) begin
      set_mode(code, 1'b0);
      chk(err, "R8 err flag", err, 1);
      @(negedge clk); rd_cmd = 1'b1;
      @(negedge clk); rd_cmd = 1'b0; stb = 1'b1;
      @(negedge clk); stb = 1'b0;
      for (int k = 0; k < 10; k++) begin
        @(negedge clk);
        chk(!busy && !rd_en && !wr_en, "R8 no access", {busy, rd_en, wr_en}, 0);
      end
    end

    // R9 and R10: traffic and mode change during a latency-7 read
    set_mode(7, 1'b1);
    access(1'b0, 1'b1, 7, 9'h0C6, 1'b1);
    set_mode(6, 1'b0);
    access(1'b1, 1'b0, 6, 9'h13D, 1'b1);

    // R11 stray strobe
    @(negedge clk); stb = 1'b1; col = 9'h055;
    @(negedge clk); stb = 1'b0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      chk(!busy && !rd_en && !wr_en, "R11 stray strobe", {busy, rd_en, wr_en}, 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule